// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block holds a byte-addressed bank of shared counters that many requesters update without locks. A request arrives on a valid/ready port and carries a 64-bit command word. Counter fields are 8, 16, 32 or 64 bits wide and live in 2048 bytes of storage. Every read-modify-write goes through one execution stage, one request per cycle, so updates to the same counter never get lost.

There are three kinds of request. A store either adds its data to a counter or overwrites the counter with it. A load adds a signed increment that travels inside the command word and returns the value the counter held before the add. An asynchronous request does the same add, but its old value leaves as a single 64-bit word on a scratch-write port, together with the scratch word index taken from the command. Loads and asynchronous requests may wait on an external tag-switch-pending signal. If the signal stays high for a programmable number of cycles, the request gives up. In that case it leaves the counter as it was and returns an error flag instead of the value.

Top module: `atomic_ctr_bank`

## Requirements
- R1: After reset, every counter reads as zero, `req_ready` is high, and both `ld_valid` and `sp_valid` are low.
- R2: A store (`req_kind`=0) with command bit 13 clear adds the low field bits of `req_wdata` to the counter, modulo 2^width. The field width comes from `req_size` (0=8, 1=16, 2=32, 3=64 bits). A store produces no response.
- R3: A store with command bit 13 set overwrites the counter field with the low field bits of `req_wdata`.
- R4: A load (`req_kind`=1, or 3) adds the signed 22-bit increment in command bits 35..14. The increment is sign-extended to the field width and the add wraps. The load returns the old field value, sign-extended to 64 bits, on `rsp_data` with `ld_valid`.
- R5: With the default swizzle, the field for byte address A (command bits 10..0) occupies word A[10:3], bits 8*A[2:0] upward. Bytes outside the field are unchanged.
- R6: Address bits below the access size are ignored. A 32-bit access at 0x43 acts on 0x40.
- R7: An asynchronous request (`req_kind`=2) takes its size from command bits 12..11, not from `req_size`. It adds as a load does and returns one response with `sp_valid`. The response carries `sp_index` = command bits 63..56, and no response is ever returned on both ports at once.
- R8: A load or asynchronous request with command bit 13 set is held while `tag_pending` is high. Once `tag_pending` drops it executes, and its response has bit 63 clear with bits 62..0 holding the sign-extended old value.
- R9: If `tag_pending` stays high for `tmo_limit` cycles after a waiting request is accepted, the response is bit 63 set with all other bits zero, and the counter is unchanged. The count restarts for every accepted request.
- R10: Back-to-back updates to one counter all take effect, one per cycle. `req_ready` is high whenever `tag_pending` is low.
- R11: A request that does not wait raises its response valid at the first rising edge after its acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_kind | input | 2 | 0 store, 1/3 load, 2 asynchronous |
| req_size | input | 2 | Field size code for stores and loads |
| req_word | input | 64 | Command word: address, flag, size, increment, scratch index |
| req_wdata | input | 64 | Store data |
| tag_pending | input | 1 | Tag switch still in progress |
| tmo_limit | input | 16 | Wait timeout in cycles |
| ld_valid | output | 1 | Load response valid |
| sp_valid | output | 1 | Scratch write valid |
| sp_index | output | 8 | Scratch word index |
| rsp_data | output | 64 | Response word |

## Verification
The bench goes after byte-lane placement. It writes a whole 64-bit word and then updates single bytes and halfwords inside it. A design that placed lanes wrongly, or that spilled a carry past the field, would disturb the neighbouring bytes on a later wide read. An 8-bit counter holding 0xFF is incremented to check wrap-around, and a negative increment is applied to a 64-bit counter to catch a missing sign extension. An unaligned address is also used, which a design that failed to mask the low address bits would treat as a different counter.

Four loads to one counter are issued on consecutive cycles. A design that raced its read-modify-write would return repeated old values and lose increments. On the tag-wait side, one request waits and succeeds and one times out. A second waiting request follows right behind the timed-out one. A timer that did not restart per request would time that second request out at once.

// File: rtl/actr_pkg.sv
package actr_pkg;
  localparam int DATA_W      = 64;
  localparam int BYTE_ADDR_W = 11;
  localparam int LANES       = DATA_W / 8;
  localparam int LANE_W      = $clog2(LANES);
  localparam int WORD_AW     = BYTE_ADDR_W - LANE_W;
  localparam int SHIFT_W     = $clog2(DATA_W) + 1;
  localparam int INC_W       = 22;
  localparam int INC_LO      = 14;
  localparam int FLAG_BIT    = 13;
  localparam int SIZE_LO     = 11;
  localparam int SCR_W       = 8;
  localparam int SCR_LO      = DATA_W - SCR_W;

  typedef enum logic [1:0] {
    KIND_STORE = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_ASYNC = 2'd2,
    KIND_LOAD2 = 2'd3
  } kind_e;

  typedef struct packed {
    logic                   is_store;
    logic                   is_async;
    logic                   overwrite;
    logic                   waits;
    logic [1:0]             size;
    logic [BYTE_ADDR_W-1:0] baddr;
    logic [DATA_W-1:0]      operand;
    logic [SCR_W-1:0]       scr;
  } stage_t;

  function automatic logic [DATA_W-1:0] sext_field(input logic [1:0] sz,
                                                   input logic [DATA_W-1:0] f);
    case (sz)
      2'd0:    return {{(DATA_W-8){f[7]}}, f[7:0]};
      2'd1:    return {{(DATA_W-16){f[15]}}, f[15:0]};
      2'd2:    return {{(DATA_W-32){f[31]}}, f[31:0]};
      default: return f;
    endcase
  endfunction
endpackage

// File: rtl/actr_lane_map.sv
module actr_lane_map import actr_pkg::*; #(
  parameter bit SWIZZLE = 1'b1
) (
  input  logic [1:0]             size,
  input  logic [BYTE_ADDR_W-1:0] baddr,
  output logic [WORD_AW-1:0]     word_idx,
  output logic [SHIFT_W-1:0]     shift,
  output logic [DATA_W-1:0]      mask
);
  logic [LANE_W:0]        nbytes;
  logic [BYTE_ADDR_W-1:0] low;
  logic [LANE_W-1:0]      swz;
  logic [BYTE_ADDR_W-1:0] eff;
  logic [LANE_W:0]        lanes_above;

  // Storage lanes run most-significant-first; the swizzle flips the
  // in-word offset so that host byte order becomes little-endian.
  always_comb begin
    nbytes      = (LANE_W+1)'(1) << size;
    low         = BYTE_ADDR_W'(nbytes - 1'b1);
    swz         = SWIZZLE ? ~low[LANE_W-1:0] : '0;
    eff         = (baddr & ~low) ^ {{(BYTE_ADDR_W-LANE_W){1'b0}}, swz};
    word_idx    = eff[BYTE_ADDR_W-1:LANE_W];
    lanes_above = (LANE_W+1)'(LANES) - {1'b0, eff[LANE_W-1:0]} - nbytes;
    shift       = {lanes_above, 3'b000};
    mask        = (size == 2'd3) ? '1 : ((DATA_W'(1) << {nbytes, 3'b000}) - 1'b1);
  end
endmodule

// File: rtl/actr_rmw.sv
module actr_rmw import actr_pkg::*; (
  input  logic [DATA_W-1:0]  cur_word,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [DATA_W-1:0]  mask,
  input  logic [1:0]         size,
  input  logic [DATA_W-1:0]  operand,
  input  logic               overwrite,
  input  logic               hold,
  output logic [DATA_W-1:0]  new_word,
  output logic [DATA_W-1:0]  old_sext
);
  logic [DATA_W-1:0] old_f;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] upd;

  always_comb begin
    old_f    = (cur_word >> shift) & mask;
    sum      = overwrite ? operand : (old_f + operand);
    upd      = hold ? old_f : sum;
    new_word = (cur_word & ~(mask << shift)) | ((upd & mask) << shift);
    old_sext = sext_field(size, old_f);
  end
endmodule

// File: rtl/actr_wait_timer.sv
module actr_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expired = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)               cnt_d = '0;
    else if (run && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/atomic_ctr_bank.sv
module atomic_ctr_bank import actr_pkg::*; #(
  parameter bit SWIZZLE = 1'b1,
  parameter int TMO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_word,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              tag_pending,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              ld_valid,
  output logic              sp_valid,
  output logic [SCR_W-1:0]  sp_index,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int WORDS = 1 << WORD_AW;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  stage_t s_q, s_d, in_req;
  logic   s_v_q, s_v_d;
  logic   accept, exec, tmo, expired;

  // request decode
  always_comb begin
    in_req.is_store  = (req_kind == KIND_STORE);
    in_req.is_async  = (req_kind == KIND_ASYNC);
    in_req.overwrite = in_req.is_store & req_word[FLAG_BIT];
    in_req.waits     = ~in_req.is_store & req_word[FLAG_BIT];
    in_req.size      = in_req.is_async ? req_word[SIZE_LO+1:SIZE_LO] : req_size;
    in_req.baddr     = req_word[BYTE_ADDR_W-1:0];
    in_req.operand   = in_req.is_store ? req_wdata :
                       {{(DATA_W-INC_W){req_word[INC_LO+INC_W-1]}},
                        req_word[INC_LO+INC_W-1:INC_LO]};
    in_req.scr       = req_word[SCR_LO +: SCR_W];
  end

  actr_wait_timer #(.CNT_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clear   (accept),
    .run     (s_v_q & s_q.waits & tag_pending),
    .limit   (tmo_limit),
    .expired (expired)
  );

  always_comb begin
    exec      = s_v_q & (~s_q.waits | ~tag_pending | expired);
    tmo       = s_q.waits & tag_pending & expired;
    req_ready = ~s_v_q | exec;
    accept    = req_valid & req_ready;
    s_v_d     = accept | (s_v_q & ~exec);
    s_d       = accept ? in_req : s_q;
  end

  logic [WORD_AW-1:0] word_idx;
  logic [SHIFT_W-1:0] shift;
  logic [DATA_W-1:0]  mask;
  logic [DATA_W-1:0]  cur_word, new_word, old_sext;
  logic [DATA_W-1:0]  mem [WORDS];

  actr_lane_map #(.SWIZZLE(SWIZZLE)) u_lane (
    .size     (s_q.size),
    .baddr    (s_q.baddr),
    .word_idx (word_idx),
    .shift    (shift),
    .mask     (mask)
  );

  assign cur_word = mem[word_idx];

  actr_rmw u_rmw (
    .cur_word  (cur_word),
    .shift     (shift),
    .mask      (mask),
    .size      (s_q.size),
    .operand   (s_q.operand),
    .overwrite (s_q.overwrite),
    .hold      (tmo),
    .new_word  (new_word),
    .old_sext  (old_sext)
  );

  // response next state
  logic              ld_v_d, sp_v_d;
  logic [DATA_W-1:0] rsp_d;
  always_comb begin
    ld_v_d = exec & ~s_q.is_store & ~s_q.is_async;
    sp_v_d = exec & s_q.is_async;
    if (!s_q.waits)  rsp_d = old_sext;
    else if (tmo)    rsp_d = {1'b1, {(DATA_W-1){1'b0}}};
    else             rsp_d = {1'b0, old_sext[DATA_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s_v_q    <= 1'b0;
      s_q      <= '0;
      ld_valid <= 1'b0;
      sp_valid <= 1'b0;
      sp_index <= '0;
      rsp_data <= '0;
    end else begin
      s_v_q    <= s_v_d;
      s_q      <= s_d;
      ld_valid <= ld_v_d;
      sp_valid <= sp_v_d;
      if (exec) begin
        sp_index <= s_q.scr;
        rsp_data <= rsp_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (exec && !tmo) begin
      mem[word_idx] <= new_word;
    end
  end
endmodule

// File: rtl/atomic_ctr_bank_chk.sv
module atomic_ctr_bank_chk import actr_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [DATA_W-1:0] req_word,
  input logic              tag_pending,
  input logic              ld_valid,
  input logic              sp_valid
);
  // R10
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_pending |-> req_ready);

  // R7
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && sp_valid));

  // R2
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == KIND_STORE) |=> ##1 !(ld_valid || sp_valid));

  // R11
  load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[0] && !req_word[FLAG_BIT]) |=> ##1 ld_valid);

  // R11
  async_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == KIND_ASYNC && !req_word[FLAG_BIT]) |=> ##1 sp_valid);
endmodule

bind atomic_ctr_bank atomic_ctr_bank_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_kind    (req_kind),
  .req_word    (req_word),
  .tag_pending (tag_pending),
  .ld_valid    (ld_valid),
  .sp_valid    (sp_valid)
);

// File: tb/atomic_ctr_bank_bench.sv
`timescale 1ns/1ps
module atomic_ctr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [1:0]  req_size;
  logic [63:0] req_word;
  logic [63:0] req_wdata;
  logic        tag_pending;
  logic [15:0] tmo_limit;
  logic        ld_valid;
  logic        sp_valid;
  logic [7:0]  sp_index;
  logic [63:0] rsp_data;

  always #2 clk = ~clk;

  atomic_ctr_bank u_atomic_ctr_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_size(req_size), .req_word(req_word),
    .req_wdata(req_wdata), .tag_pending(tag_pending), .tmo_limit(tmo_limit),
    .ld_valid(ld_valid), .sp_valid(sp_valid), .sp_index(sp_index),
    .rsp_data(rsp_data)
  );

  typedef struct {
    bit          is_sp;
    logic [7:0]  idx;
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] mdl [256];
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          last_acc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [63:0] mk(input logic [10:0] r, input logic [1:0] sz,
                                     input logic fl, input logic [21:0] inc,
                                     input logic [7:0] scr);
    return {scr, 8'd1, 12'd0, inc, fl, sz, r};
  endfunction

  // driver: update the model, queue the expected response, present request
  task automatic send(input logic [1:0] kind, input logic [63:0] word,
                      input logic [63:0] wdata, input logic [1:0] size,
                      input bit exp_tmo, input string tag);
    bit          st, as, fl;
    logic [1:0]  sz;
    logic [10:0] a;
    int          sh, nb;
    logic [63:0] mask, op, old, nw, sx, rsp;
    exp_t        e;
    st = (kind == 2'd0);
    as = (kind == 2'd2);
    fl = word[13];
    sz = as ? word[12:11] : size;
    a  = word[10:0] & ~((11'd1 << sz) - 11'd1);
    sh = 8 * int'(a[2:0]);
    nb = 8 << sz;
    mask = (nb == 64) ? '1 : ((64'd1 << nb) - 64'd1);
    op   = st ? wdata : {{42{word[35]}}, word[35:14]};
    old  = (mdl[a[10:3]] >> sh) & mask;
    if (exp_tmo)      nw = old;
    else if (st && fl) nw = op;
    else              nw = old + op;
    mdl[a[10:3]] = (mdl[a[10:3]] & ~(mask << sh)) | ((nw & mask) << sh);
    sx = old;
    if (nb < 64 && old[nb-1]) sx = old | ~mask;
    if (!st && fl) rsp = exp_tmo ? {1'b1, 63'd0} : {1'b0, sx[62:0]};
    else           rsp = sx;
    if (!st) begin
      e.is_sp = as; e.idx = word[63:56]; e.data = rsp; e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_word = word;
    req_wdata = wdata; req_size = size;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    last_acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (ld_valid || sp_valid)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected response", rsp_data, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(sp_valid == e.is_sp, {e.tag, " port"}, {63'd0, sp_valid}, {63'd0, e.is_sp});
        chk(rsp_data === e.data, e.tag, rsp_data, e.data);
        if (e.is_sp) chk(sp_index === e.idx, {e.tag, " index"}, {56'd0, sp_index}, {56'd0, e.idx});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    int c0;
    for (int i = 0; i < 256; i++) mdl[i] = 64'd0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_size = 2'd0;
    req_word = '0; req_wdata = '0; tag_pending = 1'b0; tmo_limit = 16'd10;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_ready === 1'b1 && ld_valid === 1'b0 && sp_valid === 1'b0,
        "R1 idle ports", {61'd0, req_ready, ld_valid, sp_valid}, 64'd4);
    send(2'd1, mk(11'h000, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd3, 1'b0, "R1 word 0 zero");
    send(2'd1, mk(11'h7FF, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd0, 1'b0, "R1 last byte zero");
    drain();

    // R2 store add, with wrap on an 8-bit field
    send(2'd0, mk(11'h010, 2'd0, 1'b0, 22'd0, 8'd0), 64'd5, 2'd2, 1'b0, "R2");
    send(2'd0, mk(11'h010, 2'd0, 1'b0, 22'd0, 8'd0), 64'd7, 2'd2, 1'b0, "R2");
    send(2'd1, mk(11'h010, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd2, 1'b0, "R2 sum");
    send(2'd0, mk(11'h030, 2'd0, 1'b1, 22'd0, 8'd0), 64'hF0, 2'd0, 1'b0, "R3");
    send(2'd0, mk(11'h030, 2'd0, 1'b0, 22'd0, 8'd0), 64'h25, 2'd0, 1'b0, "R2");
    send(2'd1, mk(11'h030, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd0, 1'b0, "R2 wrap");

    // R3 overwrite inside a wider counter, R5 lanes
    send(2'd0, mk(11'h012, 2'd0, 1'b1, 22'd0, 8'd0), 64'hBEEF, 2'd1, 1'b0, "R3");
    send(2'd1, mk(11'h012, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd1, 1'b0, "R3 halfword");
    send(2'd1, mk(11'h010, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd2, 1'b0, "R5 upper half lane");

    // R4 wrap of a byte, R5 neighbours untouched
    send(2'd0, mk(11'h020, 2'd0, 1'b1, 22'd0, 8'd0), 64'h8877665544332211, 2'd3, 1'b0, "R3");
    send(2'd0, mk(11'h021, 2'd0, 1'b1, 22'd0, 8'd0), 64'hFF, 2'd0, 1'b0, "R3");
    send(2'd1, mk(11'h021, 2'd0, 1'b0, 22'd1, 8'd0), 64'd0, 2'd0, 1'b0, "R4 byte old -1");
    send(2'd1, mk(11'h021, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd0, 1'b0, "R4 byte wrapped");
    send(2'd1, mk(11'h020, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd3, 1'b0, "R5 neighbours");

    // R4 negative increment, R6 alignment
    send(2'd1, mk(11'h040, 2'd0, 1'b0, 22'h3FFFFD, 8'd0), 64'd0, 2'd3, 1'b0, "R4 neg old");
    send(2'd1, mk(11'h040, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd3, 1'b0, "R4 neg result");
    send(2'd1, mk(11'h043, 2'd0, 1'b0, 22'd1, 8'd0), 64'd0, 2'd2, 1'b0, "R6 unaligned");
    send(2'd1, mk(11'h040, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd3, 1'b0, "R6 after");

    // R7 asynchronous, size from the command word
    send(2'd2, mk(11'h100, 2'd1, 1'b0, 22'h1234, 8'h2A), 64'd0, 2'd0, 1'b0, "R7 first");
    send(2'd2, mk(11'h100, 2'd1, 1'b0, 22'd0, 8'h2B), 64'd0, 2'd3, 1'b0, "R7 second");
    drain();

    // R10 back-to-back on one counter
    send(2'd1, mk(11'h080, 2'd0, 1'b0, 22'd1, 8'd0), 64'd0, 2'd2, 1'b0, "R10 0");
    c0 = last_acc;
    send(2'd1, mk(11'h080, 2'd0, 1'b0, 22'd1, 8'd0), 64'd0, 2'd2, 1'b0, "R10 1");
    send(2'd1, mk(11'h080, 2'd0, 1'b0, 22'd1, 8'd0), 64'd0, 2'd2, 1'b0, "R10 2");
    send(2'd1, mk(11'h080, 2'd0, 1'b0, 22'd1, 8'd0), 64'd0, 2'd2, 1'b0, "R10 3");
    chk(last_acc - c0 == 3, "R10 one per cycle", 64'(last_acc - c0), 64'd3);
    drain();

    // R8 wait then succeed
    tag_pending = 1'b1; tmo_limit = 16'd40;
    send(2'd1, mk(11'h080, 2'd0, 1'b1, 22'd5, 8'd0), 64'd0, 2'd2, 1'b0, "R8 waited");
    repeat (5) @(negedge clk);
    chk(ld_valid === 1'b0, "R8 held while pending", {63'd0, ld_valid}, 64'd0);
    tag_pending = 1'b0;
    drain();
    send(2'd1, mk(11'h080, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd2, 1'b0, "R8 applied");
    drain();

    // R9 timeout, then a fresh wait that must not inherit the count
    tag_pending = 1'b1; tmo_limit = 16'd6;
    send(2'd1, mk(11'h080, 2'd0, 1'b1, 22'd7, 8'd0), 64'd0, 2'd2, 1'b1, "R9 timeout");
    send(2'd1, mk(11'h080, 2'd0, 1'b1, 22'd2, 8'd0), 64'd0, 2'd2, 1'b0, "R9 restart");
    repeat (3) @(negedge clk);
    tag_pending = 1'b0;
    drain();
    send(2'd1, mk(11'h080, 2'd0, 1'b0, 22'd0, 8'd0), 64'd0, 2'd2, 1'b0, "R9 unchanged");
    drain();

    // R9 asynchronous timeout leaves the counter alone
    tag_pending = 1'b1; tmo_limit = 16'd2;
    send(2'd2, mk(11'h100, 2'd1, 1'b1, 22'd9, 8'h05), 64'd0, 2'd0, 1'b1, "R9 async timeout");
    drain();
    tag_pending = 1'b0;
    send(2'd2, mk(11'h100, 2'd1, 1'b0, 22'd0, 8'h06), 64'd0, 2'd0, 1'b0, "R9 async unchanged");
    drain();

    chk(exp_q.size() == 0, "R7 all responses delivered", 64'(exp_q.size()), 64'd0);
    summary();
    $finish;
  end
endmodule